// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns raw PWM phase signals into high-side and low-side drive pairs for a half-bridge power stage. For each pair, a small state machine holds both switches off for a programmable number of clocks before either side is allowed to turn on. That gap is the dead time, and it keeps the two switches of a leg from ever conducting together. Turn-off is immediate.

One 8-bit configuration register controls the block:
- A channel-count bit selects one-phase operation (only U is passed on, for six-step drive) or three-phase operation (U, V and W, for sinewave drive).
- An enable bit turns dead-time insertion on or off.
- A 6-bit code sets the dead time.

The code is write-once after reset. The enable bit locks as well, but only while three-phase operation is selected. This stops software from switching the protection off by accident.

Each pair state machine has three states:
- `S_BLANK`: both outputs low, counting.
- `S_HIGH`: high side on.
- `S_LOW`: low side on.

It has five transitions:
- *settle_hi*: `S_BLANK`→`S_HIGH`, when the input is high and the count has reached the dead time.
- *settle_lo*: `S_BLANK`→`S_LOW`, when the input is low and the count has reached the dead time.
- *drop_hi*: `S_HIGH`→`S_BLANK`, when the input falls.
- *drop_lo*: `S_LOW`→`S_BLANK`, when the input rises.
- *restart*: `S_BLANK`→`S_BLANK` with the count set to 1, when the input changes during blanking.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset the configuration register reads 0xFF. `cfg_rdata` always shows the current register contents. Bit 7 is `sel3`, bit 6 is `dten`, and bits 5:0 are the dead-time code.
- R2: Bits 5:0 take the value of the first write after reset. Every later write leaves them unchanged until the next reset.
- R3: Every write made while bit 7 currently reads 1 arms an enable lock. While the lock is armed and bit 7 reads 1, writes leave bit 6 unchanged. While bit 7 reads 0, bit 6 is freely writable. A blocked bit does not stop the other bits of the same write from updating.
- R4: Bit 7 takes the written value on every write.
- R5: The dead time N, in clocks, is set by the code:
  - code[5:4]=00: N = (code[3:0]+1)×2.
  - code[5:4]=01: N = (code[3:0]+1)×4.
  - code[5]=1: N = (code[4:0]+1)×8.
- R6: With `dten`=1, an output rises N clock edges after the edge that first samples its input at the new level. During those edges the input must stay at that level.
- R7: With `dten`=1, an output falls at the first clock edge that samples its input leaving the driving level.
- R8: With `dten`=1, an input level held for N or fewer sampling edges never turns on the corresponding output.
- R9: With `dten`=1, `hs_out[i]` and `ls_out[i]` are never both high.
- R10: With `sel3`=1 and `dten`=0, each `hs_out[i]` is the input registered by one clock, and each `ls_out[i]` is its exact inverse.
- R11: With `sel3`=0, the V and W outputs (indices 1 and 2) are low. With `sel3`=0 and `dten`=0, `hs_out[0]` is U registered by one clock and `ls_out[0]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| pwm_in | input | 3 | Raw PWM inputs; bit 0 U, bit 1 V, bit 2 W |
| hs_out | output | 3 | High-side drives |
| ls_out | output | 3 | Low-side drives |

## Verification
The hardest states to reach are the lock corners of the configuration register. Once a write has been made, each code stays fixed until reset. The enable lock can only be escaped by first clearing `sel3` and then writing bit 6 in a separate write. The stimulus therefore runs several reset epochs, one per code range. Each epoch walks a fixed write sequence that attempts blocked writes and then reaches all four mode combinations.

Between writes, random PWM levels are held for 1 to 20 clocks. This forces pulses both shorter and longer than the dead time. It also produces input changes in the middle of a dead-time count. A separate directed measurement times one rising edge against the code mapping.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int CODE_W = 6;
    localparam int CFG_W  = 8;
    localparam int CNT_W  = 9;

    typedef enum logic [1:0] {
        S_BLANK = 2'd0,
        S_HIGH  = 2'd1,
        S_LOW   = 2'd2
    } pair_state_t;

    // Dead time in clocks from the 6-bit code (three resolutions).
    function automatic logic [CNT_W-1:0] dead_clocks(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] base;
        if (code[5]) begin
            base = CNT_W'(code[4:0]) + CNT_W'(1);
            return base << 3;
        end else if (code[4]) begin
            base = CNT_W'(code[3:0]) + CNT_W'(1);
            return base << 2;
        end else begin
            base = CNT_W'(code[3:0]) + CNT_W'(1);
            return base << 1;
        end
    endfunction
endpackage

// File: rtl/cpwm_cfg.sv
module cpwm_cfg
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    localparam int SEL_BIT = CFG_W - 1;
    localparam int EN_BIT  = CFG_W - 2;

    logic code_lock;
    logic en_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '1;
            code_lock <= 1'b0;
            en_lock   <= 1'b0;
        end else if (we) begin
            cfg_q[SEL_BIT] <= wdata[SEL_BIT];
            if (!(cfg_q[SEL_BIT] && en_lock))
                cfg_q[EN_BIT] <= wdata[EN_BIT];
            if (!code_lock)
                cfg_q[CODE_W-1:0] <= wdata[CODE_W-1:0];
            code_lock <= 1'b1;
            if (cfg_q[SEL_BIT])
                en_lock <= 1'b1;
        end
    end

    p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && code_lock) |=> $stable(cfg_q[CODE_W-1:0]));

    p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && en_lock && cfg_q[SEL_BIT]) |=> $stable(cfg_q[EN_BIT]));

    p_sel_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q[SEL_BIT] == $past(wdata[SEL_BIT])));
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [CNT_W-1:0] dead,
    output logic             hi,
    output logic             lo
);
    pair_state_t      state_q, state_d;
    logic             tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BLANK;
            tgt_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_HIGH: if (!pin) begin          // drop_hi
                state_d = S_BLANK;
                tgt_d   = 1'b0;
                cnt_d   = CNT_W'(1);
            end
            S_LOW: if (pin) begin            // drop_lo
                state_d = S_BLANK;
                tgt_d   = 1'b1;
                cnt_d   = CNT_W'(1);
            end
            S_BLANK: begin
                if (pin != tgt_q) begin      // restart
                    tgt_d = pin;
                    cnt_d = CNT_W'(1);
                end else if (cnt_q >= dead) begin
                    state_d = tgt_q ? S_HIGH : S_LOW;   // settle_hi / settle_lo
                end else if (cnt_q != '1) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = S_BLANK;
        endcase
    end

    // Outputs
    always_comb begin
        hi = (state_q == S_HIGH);
        lo = (state_q == S_LOW);
    end

    p_fall_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi && !pin) |=> !hi);

    p_rise_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi) |-> ($past(pin) && !$past(lo)));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int NPH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [NPH-1:0]   pwm_in,
    output logic [NPH-1:0]   hs_out,
    output logic [NPH-1:0]   ls_out
);
    logic [CFG_W-1:0] cfg_q;
    logic [NPH-1:0]   in_q;
    logic [CNT_W-1:0] dead;
    logic             sel3;
    logic             dten;

    cpwm_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pwm_in;
    end

    assign cfg_rdata = cfg_q;
    assign sel3      = cfg_q[CFG_W-1];
    assign dten      = cfg_q[CFG_W-2];
    assign dead      = dead_clocks(cfg_q[CODE_W-1:0]);

    for (genvar g = 0; g < NPH; g++) begin : g_pair
        logic hi_raw, lo_raw, h, l;
        logic active;

        cpwm_pair u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pwm_in[g]),
            .dead  (dead),
            .hi    (hi_raw),
            .lo    (lo_raw)
        );

        assign active = sel3 || (g == 0);

        always_comb begin
            if (!active) begin
                h = 1'b0;
                l = 1'b0;
            end else if (dten) begin
                h = hi_raw;
                l = lo_raw;
            end else if (sel3) begin
                h = in_q[g];
                l = ~in_q[g];
            end else begin
                h = in_q[g];
                l = 1'b0;
            end
        end

        assign hs_out[g] = h;
        assign ls_out[g] = l;
    end

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dten |-> ((hs_out & ls_out) == '0));

    p_idle_pairs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel3 |-> ((hs_out[NPH-1:1] == '0) && (ls_out[NPH-1:1] == '0)));

    p_exact_inverse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel3 && !dten) |-> ((hs_out ^ ls_out) == '1));
endmodule

// File: tb/cpwm_deadband_test.sv
module cpwm_deadband_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [2:0] pwm_in = 3'b000;
    logic [2:0] hs_out, ls_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cpwm_deadband uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pwm_in(pwm_in), .hs_out(hs_out), .ls_out(ls_out)
    );

    function automatic int dead_of(input logic [5:0] c);
        if (c[5]) return (int'(c[4:0]) + 1) * 8;
        if (c[4]) return (int'(c[3:0]) + 1) * 4;
        return (int'(c[3:0]) + 1) * 2;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_cfg;
    bit m_clock, m_elock;
    bit last [3];
    bit mh [3];
    bit ml [3];
    int run [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 8'hFF; m_clock = 0; m_elock = 0;
            for (int c = 0; c < 3; c++) begin
                last[c] = 0; mh[c] = 0; ml[c] = 0; run[c] = 0;
            end
        end else begin
            int n;
            n = dead_of(m_cfg[5:0]);
            for (int c = 0; c < 3; c++) begin
                bit x;
                x = pwm_in[c];
                if (x == last[c]) run[c]++; else run[c] = 1;
                last[c] = x;
                mh[c] = x ? (mh[c] || run[c] > n) : 1'b0;
                ml[c] = !x ? (ml[c] || run[c] > n) : 1'b0;
            end
            if (cfg_we) begin
                bit p;
                p = m_cfg[7];
                m_cfg[7] = cfg_wdata[7];
                if (!(p && m_elock)) m_cfg[6] = cfg_wdata[6];
                if (!m_clock) m_cfg[5:0] = cfg_wdata[5:0];
                m_clock = 1;
                if (p) m_elock = 1;
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            check("R1 rdata", cfg_rdata, m_cfg);
            for (int c = 0; c < 3; c++) begin
                bit act, eh, el;
                act = m_cfg[7] || (c == 0);
                if (!act)          begin eh = 0;       el = 0;        end
                else if (m_cfg[6]) begin eh = mh[c];   el = ml[c];    end
                else if (m_cfg[7]) begin eh = last[c]; el = !last[c]; end
                else               begin eh = last[c]; el = 0;        end
                if (!m_cfg[7])     tag = "R11";
                else if (!m_cfg[6]) tag = "R10";
                else               tag = "R6 R7 R8";
                check(tag, {hs_out[c], ls_out[c]}, {eh, el});
            end
            if (m_cfg[6]) check("R9 overlap", int'(hs_out & ls_out), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rnd(input int len);
        int t = 0;
        while (t < len) begin
            int h;
            h = $urandom_range(1, 20);
            @(negedge clk);
            pwm_in = 3'($urandom);
            cyc(h - 1);
            t += h;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pwm_in = 3'b000;
        cfg_we = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        check("R1 reset value", cfg_rdata, 8'hFF);
    endtask

    initial begin
        logic [5:0] codes [3];
        codes[0] = 6'h03;
        codes[1] = 6'h12;
        codes[2] = 6'h21;
        for (int e = 0; e < 3; e++) begin
            int n, k;
            bit seen;
            logic [7:0] c8;
            c8 = {2'b00, codes[e]};
            n = dead_of(codes[e]);
            do_reset();
            rnd(700);
            wr(8'hC0 | c8);
            check("R2 first write", cfg_rdata, 8'hC0 | c8);

            // R5: time one rising edge
            pwm_in = 3'b000;
            cyc(300);
            @(negedge clk);
            pwm_in = 3'b111;
            k = 0;
            while (!hs_out[0] && k < 400) begin
                @(negedge clk);
                k++;
            end
            check("R5 dead time", k - 1, n);

            // R8: input high for exactly N sampling edges
            pwm_in = 3'b000;
            cyc(300);
            @(negedge clk);
            pwm_in = 3'b001;
            seen = 0;
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                seen |= hs_out[0];
            end
            pwm_in = 3'b000;
            for (int i = 0; i < 2 * n; i++) begin
                @(negedge clk);
                seen |= hs_out[0];
            end
            check("R8 short pulse", seen, 0);

            rnd(400);
            wr(8'hC0);
            check("R2 code locked", cfg_rdata, 8'hC0 | c8);
            wr(8'h85);
            check("R3 enable locked", cfg_rdata, 8'hC0 | c8);
            rnd(300);
            wr(8'h05);
            check("R4 sel cleared, R3 en held", cfg_rdata, 8'h40 | c8);
            rnd(400);
            wr(8'h05);
            check("R3 enable free", cfg_rdata, c8);
            rnd(400);
            wr(8'h40);
            check("R3 enable set", cfg_rdata, 8'h40 | c8);
            rnd(400);
            wr(8'h80);
            check("R4 sel set", cfg_rdata, 8'h80 | c8);
            rnd(400);
            wr(8'hC0);
            check("R3 relocked", cfg_rdata, 8'h80 | c8);
            rnd(300);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule